// File: doc/BRIEF.md
# AXI4-Lite Register Access Bridge

This block terminates an AXI4-Lite slave port and turns each accepted bus transaction into a single access on a simple internal register port. The internal port has one shared word address, a write-data bus, a one-cycle write strobe answered by a write acknowledge, and a one-cycle read strobe answered by a read acknowledge that qualifies the returned read data. Behind it sits whatever register file the chip places there.

Reads and writes share a single access slot, so only one transaction is in flight at any time. When a complete write (address and data both valid) and a read are offered in the same cycle, the write is taken and the read waits until the write's response handshake has finished. This priority is fixed and unfair: a steady stream of writes can hold off reads indefinitely. After the response is presented, the slot stays occupied until the master accepts it. No address window is checked, because every request that reaches the port is treated as addressed to it. The protection inputs exist on the interface and have no effect.

Top module: `axil_reg_bridge`

## Requirements
- R1: A write is taken only when `s_awvalid` and `s_wvalid` are both high in the idle slot. One cycle later `s_awready` and `s_wready` go high together for exactly one cycle. An address without data does not block a read.
- R2: When a complete write and `s_arvalid` are both present in the idle slot, the write is granted. `s_arready` is raised only after the write's B handshake has completed.
- R3: Only one transaction is in flight. No ready pulse on any address channel occurs from a grant until the cycle after the matching response handshake. `reg_wr_req` and `reg_rd_req` are never high together.
- R4: The cycle after the write handshake, `reg_wr_req` is high for one cycle with the captured address and `s_wdata` on `reg_wdata`. The cycle after `reg_wr_ack` is seen (from the request cycle onward), `s_bvalid` rises with `s_bresp` = 2'b00 (OKAY).
- R5: The cycle after the read handshake, `reg_rd_req` is high for one cycle. `reg_rdata` is captured in the cycle `reg_rd_ack` is high. The next cycle `s_rvalid` rises with that data and `s_rresp` = 2'b00 (OKAY). `reg_rdata` outside the acknowledge cycle has no effect.
- R6: `s_bvalid`, `s_rvalid` and `s_rdata` hold steady while the matching ready is low. A valid falls the cycle after the ready handshake.
- R7: `reg_addr` is the word address, AXI address bits [REG_ADDR_W+1:2] for 32-bit data. Any address, including the top of the AXI space, is forwarded with no range check.
- R8: `s_awprot` and `s_arprot` have no effect on any output.
- R9: A synchronous active-high `rst` clears every ready, valid and request output on the next edge and returns the slot to idle, even during an outstanding response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_awaddr | input | AXI_ADDR_W | Write address |
| s_awprot | input | 3 | Write protection, unused |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AXI_ADDR_W | Read address |
| s_arprot | input | 3 | Read protection, unused |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| reg_addr | output | REG_ADDR_W | Internal word address |
| reg_wdata | output | DATA_W | Internal write data |
| reg_wr_req | output | 1 | Internal write strobe |
| reg_wr_ack | input | 1 | Internal write acknowledge |
| reg_rd_req | output | 1 | Internal read strobe |
| reg_rd_ack | input | 1 | Internal read acknowledge |
| reg_rdata | input | DATA_W | Internal read data |

## Verification
Single writes and reads with zero and multi-cycle internal acknowledge delay confirm the basic latency, response codes and end-to-end data. A write and a read raised in the same cycle separate write-first arbitration from any other order. An address offered alone next to a read shows that an incomplete write does not win. Held-low BREADY and RREADY, together with back-to-back bursts, show whether the slot is wrongly freed before the response handshake. A top-of-space address, varied protection bits and a reset during a pending response cover address forwarding, the ignored inputs and recovery.

// File: rtl/axil_bridge_pkg.sv
package axil_bridge_pkg;

  typedef enum logic [2:0] {
    SL_IDLE,
    SL_W_ACC,
    SL_W_WAIT,
    SL_B_RESP,
    SL_R_ACC,
    SL_R_WAIT,
    SL_R_RESP
  } slot_state_e;

  typedef enum logic [1:0] {
    GR_NONE,
    GR_WRITE,
    GR_READ
  } grant_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axil_grant.sv
module axil_grant
  import axil_bridge_pkg::*;
(
  input  logic   slot_free,
  input  logic   wr_pair,
  input  logic   rd_ask,
  output grant_e grant
);

  // fixed priority: a complete write always beats a read
  always_comb begin
    if (!slot_free)   grant = GR_NONE;
    else if (wr_pair) grant = GR_WRITE;
    else if (rd_ask)  grant = GR_READ;
    else              grant = GR_NONE;
  end

endmodule

// File: rtl/axil_slot_fsm.sv
module axil_slot_fsm
  import axil_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_pair,
  input  logic rd_ask,
  input  logic wr_ack,
  input  logic rd_ack,
  input  logic bready,
  input  logic rready,
  output logic awready,
  output logic wready,
  output logic arready,
  output logic bvalid,
  output logic rvalid,
  output logic wr_req,
  output logic rd_req,
  output logic ld_waddr,
  output logic ld_raddr,
  output logic ld_rdata
);

  slot_state_e state;
  grant_e      grant;

  axil_grant u_grant (
    .slot_free (state == SL_IDLE),
    .wr_pair   (wr_pair),
    .rd_ask    (rd_ask),
    .grant     (grant)
  );

  assign ld_waddr = (state == SL_W_ACC);
  assign ld_raddr = (state == SL_R_ACC);
  assign ld_rdata = (state == SL_R_WAIT) && rd_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SL_IDLE;
      awready <= 1'b0;
      wready  <= 1'b0;
      arready <= 1'b0;
      bvalid  <= 1'b0;
      rvalid  <= 1'b0;
      wr_req  <= 1'b0;
      rd_req  <= 1'b0;
    end else begin
      awready <= 1'b0;
      wready  <= 1'b0;
      arready <= 1'b0;
      wr_req  <= 1'b0;
      rd_req  <= 1'b0;
      case (state)
        SL_IDLE: begin
          case (grant)
            GR_WRITE: begin
              state   <= SL_W_ACC;
              awready <= 1'b1;
              wready  <= 1'b1;
            end
            GR_READ: begin
              state   <= SL_R_ACC;
              arready <= 1'b1;
            end
            default: ;
          endcase
        end
        SL_W_ACC: begin
          state  <= SL_W_WAIT;
          wr_req <= 1'b1;
        end
        SL_W_WAIT: begin
          if (wr_ack) begin
            state  <= SL_B_RESP;
            bvalid <= 1'b1;
          end
        end
        SL_B_RESP: begin
          if (bready) begin
            state  <= SL_IDLE;
            bvalid <= 1'b0;
          end
        end
        SL_R_ACC: begin
          state  <= SL_R_WAIT;
          rd_req <= 1'b1;
        end
        SL_R_WAIT: begin
          if (rd_ack) begin
            state  <= SL_R_RESP;
            rvalid <= 1'b1;
          end
        end
        SL_R_RESP: begin
          if (rready) begin
            state  <= SL_IDLE;
            rvalid <= 1'b0;
          end
        end
        default: state <= SL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/axil_addr_map.sv
module axil_addr_map #(
  parameter int AXI_ADDR_W = 16,
  parameter int REG_ADDR_W = 14,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  ld_waddr,
  input  logic                  ld_raddr,
  input  logic [AXI_ADDR_W-1:0] awaddr,
  input  logic [AXI_ADDR_W-1:0] araddr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [REG_ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0]     reg_wdata
);

  localparam int LSB   = $clog2(DATA_W / 8);
  localparam int AVAIL = AXI_ADDR_W - LSB;

  logic [REG_ADDR_W-1:0] aw_word;
  logic [REG_ADDR_W-1:0] ar_word;
  logic                  unused_addr_bits;

  generate
    if (AVAIL >= REG_ADDR_W) begin : g_slice
      assign aw_word = awaddr[LSB +: REG_ADDR_W];
      assign ar_word = araddr[LSB +: REG_ADDR_W];
    end else begin : g_extend
      assign aw_word = {{(REG_ADDR_W - AVAIL){1'b0}}, awaddr[AXI_ADDR_W-1:LSB]};
      assign ar_word = {{(REG_ADDR_W - AVAIL){1'b0}}, araddr[AXI_ADDR_W-1:LSB]};
    end
  endgenerate

  // byte-lane and out-of-range bits carry no meaning here
  assign unused_addr_bits = ^{awaddr, araddr};

  always_ff @(posedge clk) begin
    if (ld_waddr) begin
      reg_addr  <= aw_word;
      reg_wdata <= wdata;
    end else if (ld_raddr) begin
      reg_addr  <= ar_word;
    end
  end

endmodule

// File: rtl/axil_rdata_hold.sv
module axil_rdata_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              ld,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (ld) q <= d;
  end

endmodule

// File: rtl/axil_reg_bridge.sv
module axil_reg_bridge
  import axil_bridge_pkg::*;
#(
  parameter int AXI_ADDR_W = 16,
  parameter int REG_ADDR_W = 14,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AXI_ADDR_W-1:0] s_awaddr,
  input  logic [2:0]            s_awprot,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [DATA_W-1:0]     s_wdata,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  output logic [1:0]            s_bresp,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  input  logic [AXI_ADDR_W-1:0] s_araddr,
  input  logic [2:0]            s_arprot,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  output logic [DATA_W-1:0]     s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic [REG_ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0]     reg_wdata,
  output logic                  reg_wr_req,
  input  logic                  reg_wr_ack,
  output logic                  reg_rd_req,
  input  logic                  reg_rd_ack,
  input  logic [DATA_W-1:0]     reg_rdata
);

  logic ld_waddr;
  logic ld_raddr;
  logic ld_rdata;
  logic unused_prot;

  // protection attributes are accepted but carry no meaning here
  assign unused_prot = ^{s_awprot, s_arprot};

  assign s_bresp = RESP_OKAY;
  assign s_rresp = RESP_OKAY;

  axil_slot_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .wr_pair  (s_awvalid && s_wvalid),
    .rd_ask   (s_arvalid),
    .wr_ack   (reg_wr_ack),
    .rd_ack   (reg_rd_ack),
    .bready   (s_bready),
    .rready   (s_rready),
    .awready  (s_awready),
    .wready   (s_wready),
    .arready  (s_arready),
    .bvalid   (s_bvalid),
    .rvalid   (s_rvalid),
    .wr_req   (reg_wr_req),
    .rd_req   (reg_rd_req),
    .ld_waddr (ld_waddr),
    .ld_raddr (ld_raddr),
    .ld_rdata (ld_rdata)
  );

  axil_addr_map #(
    .AXI_ADDR_W (AXI_ADDR_W),
    .REG_ADDR_W (REG_ADDR_W),
    .DATA_W     (DATA_W)
  ) u_map (
    .clk       (clk),
    .ld_waddr  (ld_waddr),
    .ld_raddr  (ld_raddr),
    .awaddr    (s_awaddr),
    .araddr    (s_araddr),
    .wdata     (s_wdata),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
  );

  axil_rdata_hold #(
    .DATA_W (DATA_W)
  ) u_rhold (
    .clk (clk),
    .ld  (ld_rdata),
    .d   (reg_rdata),
    .q   (s_rdata)
  );

endmodule

// File: rtl/axil_reg_bridge_chk.sv
module axil_reg_bridge_chk #(
  parameter int AXI_ADDR_W = 16,
  parameter int REG_ADDR_W = 14,
  parameter int DATA_W     = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic [AXI_ADDR_W-1:0] s_awaddr,
  input logic                  s_awvalid,
  input logic                  s_awready,
  input logic                  s_wvalid,
  input logic                  s_wready,
  input logic [1:0]            s_bresp,
  input logic                  s_bvalid,
  input logic                  s_bready,
  input logic                  s_arvalid,
  input logic                  s_arready,
  input logic [DATA_W-1:0]     s_rdata,
  input logic [1:0]            s_rresp,
  input logic                  s_rvalid,
  input logic                  s_rready,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic                  reg_wr_req,
  input logic                  reg_rd_req
);

  localparam int LSB = $clog2(DATA_W / 8);

  logic unused_chk;
  assign unused_chk = ^{s_awaddr, s_arvalid};

  p_pair_ready_r1: assert property (@(posedge clk) disable iff (rst)
    s_awready == s_wready);

  p_ready_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    s_awready |=> !s_awready);

  p_write_wins_r2: assert property (@(posedge clk) disable iff (rst)
    s_arready |-> !$past(s_awvalid && s_wvalid));

  p_one_grant_r3: assert property (@(posedge clk) disable iff (rst)
    !(s_awready && s_arready));

  p_busy_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid || s_rvalid) |-> !(s_awready || s_arready));

  p_no_dual_req_r3: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_req && reg_rd_req));

  p_wreq_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    reg_wr_req |=> !reg_wr_req);

  p_bresp_okay_r4: assert property (@(posedge clk) disable iff (rst)
    s_bvalid |-> (s_bresp == 2'b00));

  p_rreq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    reg_rd_req |=> !reg_rd_req);

  p_rresp_okay_r5: assert property (@(posedge clk) disable iff (rst)
    s_rvalid |-> (s_rresp == 2'b00));

  p_bhold_r6: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> s_bvalid);

  p_rhold_r6: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

  p_waddr_map_r7: assert property (@(posedge clk) disable iff (rst)
    reg_wr_req |-> (reg_addr == $past(s_awaddr[LSB +: REG_ADDR_W])));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> !(s_awready || s_wready || s_arready || s_bvalid || s_rvalid ||
              reg_wr_req || reg_rd_req));

endmodule

bind axil_reg_bridge axil_reg_bridge_chk #(
  .AXI_ADDR_W (AXI_ADDR_W),
  .REG_ADDR_W (REG_ADDR_W),
  .DATA_W     (DATA_W)
) u_chk (.*);

// File: tb/tb_axil_reg_bridge.sv
module tb_axil_reg_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] s_awaddr = '0;
  logic [2:0]  s_awprot = '0;
  logic        s_awvalid = 1'b0;
  logic        s_awready;
  logic [31:0] s_wdata = '0;
  logic        s_wvalid = 1'b0;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready = 1'b0;
  logic [15:0] s_araddr = '0;
  logic [2:0]  s_arprot = '0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready = 1'b0;
  logic [13:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_wr_req;
  logic        reg_wr_ack = 1'b0;
  logic        reg_rd_req;
  logic        reg_rd_ack = 1'b0;
  logic [31:0] reg_rdata = 32'hBAD0_BAD0;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  axil_reg_bridge dut (.*);

  task automatic chk(input string req, input string nm,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, nm, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_ph = 0;   // 0 idle,1 w-accept,2 w-wait,3 b-resp,4 r-accept,5 r-wait,6 r-resp
  logic        e_awr = 0, e_arr = 0, e_bv = 0, e_rv = 0, e_wreq = 0, e_rreq = 0;
  logic [13:0] e_addr = '0;
  logic [31:0] e_wdata = '0, e_rdata = '0;
  bit          started = 1'b0;

  always @(posedge clk) begin
    started = 1'b1;
    e_awr = 0; e_arr = 0; e_wreq = 0; e_rreq = 0;
    if (rst) begin
      m_ph = 0; e_bv = 0; e_rv = 0;
    end else begin
      case (m_ph)
        0: if (s_awvalid && s_wvalid) begin m_ph = 1; e_awr = 1; end
           else if (s_arvalid) begin m_ph = 4; e_arr = 1; end
        1: begin m_ph = 2; e_wreq = 1; e_addr = s_awaddr[15:2]; e_wdata = s_wdata; end
        2: if (reg_wr_ack) begin m_ph = 3; e_bv = 1; end
        3: if (s_bready) begin m_ph = 0; e_bv = 0; end
        4: begin m_ph = 5; e_rreq = 1; e_addr = s_araddr[15:2]; end
        5: if (reg_rd_ack) begin m_ph = 6; e_rv = 1; e_rdata = reg_rdata; end
        6: if (s_rready) begin m_ph = 0; e_rv = 0; end
        default: m_ph = 0;
      endcase
    end
  end

  // compare once per clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1", "awready", 32'(s_awready), 32'(e_awr));
      chk("R1", "wready",  32'(s_wready),  32'(e_awr));
      chk("R2", "arready", 32'(s_arready), 32'(e_arr));
      chk("R6", "bvalid",  32'(s_bvalid),  32'(e_bv));
      chk("R6", "rvalid",  32'(s_rvalid),  32'(e_rv));
      chk("R4", "wr_req",  32'(reg_wr_req), 32'(e_wreq));
      chk("R5", "rd_req",  32'(reg_rd_req), 32'(e_rreq));
      if (e_wreq || e_rreq) chk("R7", "reg_addr", 32'(reg_addr), 32'(e_addr));
      if (e_wreq) chk("R4", "reg_wdata", reg_wdata, e_wdata);
      if (e_bv)   chk("R4", "bresp", 32'(s_bresp), 32'd0);
      if (e_rv) begin
        chk("R5", "rdata", s_rdata, e_rdata);
        chk("R5", "rresp", 32'(s_rresp), 32'd0);
      end
    end
  end

  // ---------------- internal register responder ----------------
  logic [31:0] regmem [int];
  int  wlat = 0, rlat = 0;
  int  wcnt = 0, rcnt = 0;
  bit  wpend = 0, rpend = 0;
  int  raddr_hold = 0;

  function automatic logic [31:0] rd_mem(input int a);
    if (regmem.exists(a)) return regmem[a];
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    reg_wr_ack = 1'b0;
    reg_rd_ack = 1'b0;
    reg_rdata  = 32'hBAD0_BAD0;
    if (rst) begin
      wpend = 0; rpend = 0;
    end else begin
      if (wpend) begin
        if (wcnt == 0) begin reg_wr_ack = 1'b1; wpend = 0; end else wcnt--;
      end
      if (reg_wr_req) begin
        regmem[int'(reg_addr)] = reg_wdata;
        if (wlat == 0) reg_wr_ack = 1'b1;
        else begin wpend = 1; wcnt = wlat - 1; end
      end
      if (rpend) begin
        if (rcnt == 0) begin
          reg_rd_ack = 1'b1; reg_rdata = rd_mem(raddr_hold); rpend = 0;
        end else rcnt--;
      end
      if (reg_rd_req) begin
        raddr_hold = int'(reg_addr);
        if (rlat == 0) begin reg_rd_ack = 1'b1; reg_rdata = rd_mem(raddr_hold); end
        else begin rpend = 1; rcnt = rlat - 1; end
      end
    end
  end

  // ---------------- grant order log ----------------
  string order [$];
  always @(negedge clk) begin
    if (s_awready) order.push_back("W");
    if (s_arready) order.push_back("R");
  end

  // ---------------- master tasks ----------------
  logic [31:0] shadow [int];

  task automatic axi_write(input logic [15:0] a, input logic [31:0] d,
                           input int wdly, input int bdly, input logic [2:0] prot);
    s_awaddr = a; s_awprot = prot; s_awvalid = 1'b1;
    repeat (wdly) @(negedge clk);
    s_wdata = d; s_wvalid = 1'b1;
    do @(negedge clk); while (!s_awready);
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    shadow[int'(a[15:2])] = d;
    repeat (bdly) @(negedge clk);
    s_bready = 1'b1;
    while (!s_bvalid) @(negedge clk);
    @(negedge clk);
    s_bready = 1'b0;
  endtask

  task automatic axi_read(input logic [15:0] a, input int rdly,
                          input logic [2:0] prot, input string tag);
    logic [31:0] got;
    logic [31:0] exp;
    s_araddr = a; s_arprot = prot; s_arvalid = 1'b1;
    do @(negedge clk); while (!s_arready);
    @(negedge clk);
    s_arvalid = 1'b0;
    repeat (rdly) @(negedge clk);
    s_rready = 1'b1;
    while (!s_rvalid) @(negedge clk);
    got = s_rdata;
    @(negedge clk);
    s_rready = 1'b0;
    exp = shadow.exists(int'(a[15:2])) ? shadow[int'(a[15:2])] : 32'h0;
    chk(tag, "readback", got, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, MAX_CYCLES);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state, all ready/valid/request outputs low
    chk("R9", "reset outputs",
        32'({s_awready, s_wready, s_arready, s_bvalid, s_rvalid, reg_wr_req, reg_rd_req}), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 R4: plain write, immediate acknowledge and response accept
    wlat = 0; rlat = 0;
    axi_write(16'h0010, 32'hA5A5_0001, 0, 0, 3'd0);
    // R5: read back with delayed acknowledge
    rlat = 2;
    axi_read(16'h0010, 0, 3'd0, "R5");

    // R6: slow acknowledge and held-low BREADY / RREADY
    wlat = 3; rlat = 1;
    axi_write(16'h0024, 32'h1234_5678, 0, 4, 3'd0);
    axi_read(16'h0024, 5, 3'd0, "R6");

    // R2: write and read in the same cycle, write first
    order.delete();
    wlat = 1; rlat = 0;
    fork
      axi_write(16'h0040, 32'hCAFE_0040, 0, 2, 3'd0);
      axi_read(16'h0024, 1, 3'd0, "R2");
    join
    chk("R2", "first grant is write", 32'(order.size() > 0 && order[0] == "W"), 32'd1);
    chk("R2", "second grant is read", 32'(order.size() > 1 && order[1] == "R"), 32'd1);

    // R1: address without data does not block a read
    order.delete();
    fork
      axi_write(16'h0050, 32'h0BAD_F00D, 6, 0, 3'd0);
      axi_read(16'h0040, 0, 3'd0, "R1");
    join
    chk("R1", "lone address lets read go first", 32'(order.size() > 0 && order[0] == "R"), 32'd1);

    // R3: back-to-back writes then reads with backpressure
    for (int i = 0; i < 6; i++) begin
      wlat = i % 3;
      axi_write(16'(16'h0100 + 4 * i), 32'hD000_0000 + 32'(i), 0, i % 2, 3'd0);
    end
    for (int i = 0; i < 6; i++) begin
      rlat = (i + 1) % 3;
      axi_read(16'(16'h0100 + 4 * i), i % 3, 3'd0, "R3");
    end

    // R7: top of the AXI space forwards to the top word, no range check
    wlat = 0; rlat = 0;
    axi_write(16'hFFFC, 32'h7777_FFFC, 0, 0, 3'd0);
    axi_read(16'hFFFC, 0, 3'd0, "R7");
    chk("R7", "top word stored", regmem.exists(14'h3FFF) ? regmem[14'h3FFF] : 32'h0, 32'h7777_FFFC);

    // R8: protection bits varied, outputs follow the model that ignores them
    axi_write(16'h0200, 32'h8888_0001, 0, 1, 3'd7);
    axi_read(16'h0200, 1, 3'd5, "R8");
    axi_write(16'h0200, 32'h8888_0002, 0, 0, 3'd2);
    axi_read(16'h0200, 0, 3'd1, "R8");

    // R3: mixed sequence under concurrent pressure
    for (int i = 0; i < 8; i++) begin
      wlat = i % 4; rlat = (i * 3) % 4;
      fork
        axi_write(16'(16'h0300 + 4 * i), 32'hE000_0000 ^ 32'(i * 257), i % 2, i % 3, 3'(i));
        axi_read(16'(16'h0300 + 4 * ((i + 7) % 8)), (i + 1) % 3, 3'(7 - i), "R3");
      join
    end

    // R9: reset while a write response is pending
    wlat = 0;
    s_awaddr = 16'h0400; s_wdata = 32'h5555_AAAA;
    s_awvalid = 1'b1; s_wvalid = 1'b1;
    do @(negedge clk); while (!s_awready);
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    while (!s_bvalid) @(negedge clk);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9", "bvalid cleared by reset", 32'(s_bvalid), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "slot idle after reset",
        32'({s_awready, s_arready, s_bvalid, s_rvalid}), 32'd0);
    shadow[int'(16'h0400 >> 2)] = 32'h5555_AAAA;
    axi_read(16'h0400, 0, 3'd0, "R9");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule